// File: doc/BRIEF.md
# Core Event Latch Controller

This block takes sixteen event lines and decides which of them the core services next. A rising edge on a line is caught by a two-stage sampler and recorded in a latch register. A mask register holds one enable bit per event. A global enable input also gates service. Among the events that are latched, enabled and allowed by the global enable, the lowest index wins. The winner is accepted only if it outranks every event already in service. On acceptance its bit in the pending register sets and its latch bit clears, so the line can record a new edge while the event is being handled.

A return strobe marks the end of the current handler. It clears the highest-priority pending bit, which unwinds nested events in the reverse order of entry. Software reaches the three registers through a small port. The latch register can be read, and written only in bit positions whose mask bit is clear. The mask register can be read and written. The pending register is read-only.

Top module: `evt_core_ctrl`

## Requirements
- R1: After reset the latch, mask and pending registers are all zero, and `pend_o` is zero.
- R2: A low-to-high change on `evt_i[i]` sampled at clock edge k sets latch bit i at edge k+1. A line held high does not set the bit again.
- R3: When an event is accepted, its pending bit sets and its latch bit clears at the same edge. With the mask and global enable set and nothing pending, this is edge k+2, three edges after the input rose.
- R4: A write to address 0 (latch) changes only the bits whose mask bit is 0. Bits whose mask bit is 1 keep their value.
- R5: An event whose mask bit is 0 stays latched and is never accepted. It is accepted one edge after its mask bit is written to 1.
- R6: At most one event is accepted per edge. Among the latched, enabled events, the one with the lowest index is taken.
- R7: An event is accepted only if its index is lower than the lowest index set in the pending register. Otherwise it stays latched.
- R8: With `ret_i` high at an edge, the lowest-index set pending bit clears. With no pending bit set, it does nothing. An acceptance in the same edge is judged against the pending value from before the return.
- R9: While `gie_i` is low, no event is accepted, but edges are still latched.
- R10: Once an event's pending bit is set, a new rising edge on the same line sets its latch bit again.
- R11: Read address 0 returns latch, 1 returns mask, 2 returns pending, and 3 returns zero. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| evt_i | input | 16 | Event lines, rising-edge sensitive |
| gie_i | input | 1 | Global enable for acceptance |
| ret_i | input | 1 | Return strobe, releases the top pending event |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| pend_o | output | 16 | Pending register |

## Verification
A return and an acceptance can land on the same edge. The bench provokes this by placing a higher-priority event's acceptance edge exactly on the edge where a return strobe is sampled, while a lower-priority event is pending. The expected outcome is that the old pending bit drops and the new bit sets. A second case covers a return that frees a waiting lower-priority event. That event must not be taken in the same edge, because acceptance is judged against the pending value from before the return. It is taken one edge later. A behavioural model predicts both outcomes and is compared with the outputs on every clock.

// File: rtl/evt_core_ctrl.sv
module evt_core_ctrl #(
  parameter int N  = 16,
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic          gie_i,
  input  logic          ret_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [N-1:0]  reg_wdata_i,
  output logic [N-1:0]  reg_rdata_o,
  output logic [N-1:0]  pend_o
);
  localparam logic [AW-1:0] A_LAT = AW'(0);
  localparam logic [AW-1:0] A_MSK = AW'(1);
  localparam logic [AW-1:0] A_PND = AW'(2);
  localparam logic [N-1:0]  ONE   = N'(1);

  logic [N-1:0] s1_q, s2_q, lat_q, msk_q, pnd_q;
  logic [N-1:0] edge_w, cand, win, top_p, acc, rel, lat_wm;

  assign edge_w = s1_q & ~s2_q;
  assign cand   = gie_i ? (lat_q & msk_q) : '0;
  assign win    = cand & (~cand + ONE);
  assign top_p  = pnd_q & (~pnd_q + ONE);
  assign acc    = (win != '0 && (top_p == '0 || win < top_p)) ? win : '0;
  assign rel    = ret_i ? top_p : '0;
  assign lat_wm = (reg_we_i && reg_addr_i == A_LAT) ? ~msk_q : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      lat_q <= '0;
      msk_q <= '0;
      pnd_q <= '0;
    end else begin
      s1_q  <= evt_i;
      s2_q  <= s1_q;
      lat_q <= (((lat_q & ~lat_wm) | (reg_wdata_i & lat_wm)) & ~acc) | edge_w;
      if (reg_we_i && reg_addr_i == A_MSK) msk_q <= reg_wdata_i;
      pnd_q <= (pnd_q & ~rel) | acc;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_LAT:   reg_rdata_o = lat_q;
      A_MSK:   reg_rdata_o = msk_q;
      A_PND:   reg_rdata_o = pnd_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign pend_o = pnd_q;
endmodule

// File: rtl/evt_core_ctrl_chk.sv
module evt_core_ctrl_chk #(
  parameter int N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         gie_i,
  input logic         ret_i,
  input logic [N-1:0] edge_w,
  input logic [N-1:0] lat_q,
  input logic [N-1:0] msk_q,
  input logic [N-1:0] pnd_q
);
  localparam logic [N-1:0] ONE = N'(1);

  p_one_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pnd_q & ~$past(pnd_q)) <= 1);

  p_nest_rank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pnd_q & ~$past(pnd_q)) != '0 && $past(pnd_q) != '0) |->
      ((pnd_q & ~$past(pnd_q)) < ($past(pnd_q) & (~$past(pnd_q) + ONE))));

  p_mask_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pnd_q & ~$past(pnd_q)) & ~$past(msk_q)) == '0);

  p_gie_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> ((pnd_q & ~$past(pnd_q)) == '0));

  p_accept_clears_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pnd_q & ~$past(pnd_q)) & ~$past(edge_w) & lat_q) == '0);

  p_return_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> (($past(pnd_q) & ~pnd_q) == ($past(pnd_q) & (~$past(pnd_q) + ONE))));

  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_i |=> (($past(pnd_q) & ~pnd_q) == '0));
endmodule

bind evt_core_ctrl evt_core_ctrl_chk #(.N(N)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .gie_i  (gie_i),
  .ret_i  (ret_i),
  .edge_w (edge_w),
  .lat_q  (lat_q),
  .msk_q  (msk_q),
  .pnd_q  (pnd_q)
);

// File: tb/tb_evt_core_ctrl.sv
`timescale 1ns/10ps
module tb_evt_core_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        gie = 1'b0;
  logic        ret = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata, pend;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  evt_core_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .gie_i(gie), .ret_i(ret),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .pend_o(pend)
  );

  bit [15:0] m_s1, m_s2, m_lat, m_msk, m_pnd, nl, np;
  int w, lowp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_lat = '0; m_msk = '0; m_pnd = '0;
    end else begin
      w = -1; lowp = 16;
      for (int i = 15; i >= 0; i--) if (m_pnd[i]) lowp = i;
      if (gie) for (int i = 15; i >= 0; i--) if (m_lat[i] && m_msk[i]) w = i;
      nl = m_lat;
      if (we && addr == 2'd0)
        for (int i = 0; i < 16; i++) if (!m_msk[i]) nl[i] = wd[i];
      np = m_pnd;
      if (ret && lowp < 16) np[lowp] = 1'b0;
      if (w >= 0 && w < lowp) begin np[w] = 1'b1; nl[w] = 1'b0; end
      for (int i = 0; i < 16; i++) if (m_s1[i] && !m_s2[i]) nl[i] = 1'b1;
      if (we && addr == 2'd1) m_msk = wd;
      m_lat = nl; m_pnd = np; m_s2 = m_s1; m_s1 = evt;
    end
  end

  function automatic bit [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_lat;
      2'd1: return m_msk;
      2'd2: return m_pnd;
      default: return 16'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (pend !== m_pnd || rdata !== m_read(addr)) begin
        n_bad++;
        $display("FAIL %s model: pend=%h rdata=%h expected pend=%h rdata=%h",
                 cur_req, pend, rdata, m_pnd, m_read(addr));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a; #0.2; v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wd = d; step(); we = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  logic [15:0] v;

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    steps(3);
    rst_n = 1'b1;
    step();

    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 16'h0); end
    chk("R1 pend", pend, 16'h0);

    cur_req = "R4";
    wr(2'd0, 16'h00F0); rd(2'd0, v); chk("R4 open write", v, 16'h00F0);
    wr(2'd1, 16'h00FF);
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R4 masked bits kept", v, 16'h00F0);
    wr(2'd0, 16'hFF00); rd(2'd0, v); chk("R4 partial write", v, 16'hFFF0);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0000); rd(2'd0, v); chk("R4 clear", v, 16'h0);

    cur_req = "R2 R3 R7";
    wr(2'd1, 16'hFFFF); gie = 1'b1;
    evt = 16'h0208; step();
    step(); rd(2'd0, v); chk("R2 latched", v, 16'h0208); chk("R3 not yet", pend, 16'h0);
    step(); chk("R3 pend at third edge", pend, 16'h0008);
    rd(2'd0, v); chk("R3 latch cleared", v, 16'h0200);
    steps(3); rd(2'd0, v); chk("R2 level no relatch", v, 16'h0200);
    chk("R7 lower waits", pend, 16'h0008);

    cur_req = "R8";
    pulse_ret(); chk("R8 return clears", pend, 16'h0);
    step(); chk("R8 waiting taken next", pend, 16'h0200);

    cur_req = "R7 R8";
    evt = 16'h020A; steps(3); chk("R7 higher nests", pend, 16'h0202);
    ret = 1'b1; step(); chk("R8 top released", pend, 16'h0200);
    step(); chk("R8 second release", pend, 16'h0);
    step(); chk("R8 empty return", pend, 16'h0);
    ret = 1'b0; evt = 16'h0; steps(2);

    cur_req = "R6 R8 same edge";
    evt = 16'h0200; steps(3); chk("R6 setup", pend, 16'h0200);
    evt = 16'h0204; steps(2); ret = 1'b1; step(); ret = 1'b0;
    chk("R8 return with accept", pend, 16'h0004);
    pulse_ret(); chk("R8 final", pend, 16'h0);
    evt = 16'h0; steps(2);

    cur_req = "R9";
    gie = 1'b0; evt = 16'h0001; steps(3);
    chk("R9 blocked", pend, 16'h0); rd(2'd0, v); chk("R9 still latches", v, 16'h0001);
    steps(4); chk("R9 still blocked", pend, 16'h0);
    gie = 1'b1; step(); chk("R9 enabled", pend, 16'h0001);
    rd(2'd0, v); chk("R9 latch cleared", v, 16'h0);
    pulse_ret(); evt = 16'h0; steps(2);

    cur_req = "R5";
    wr(2'd1, 16'hFF7F); evt = 16'h0080; steps(3);
    chk("R5 masked not taken", pend, 16'h0); rd(2'd0, v); chk("R5 kept latched", v, 16'h0080);
    wr(2'd1, 16'hFFFF); chk("R5 same edge as mask", pend, 16'h0);
    step(); chk("R5 taken after unmask", pend, 16'h0080);
    pulse_ret(); evt = 16'h0; steps(2);

    cur_req = "R6";
    gie = 1'b0; evt = 16'h1090; steps(3); rd(2'd0, v); chk("R6 all latched", v, 16'h1090);
    gie = 1'b1; step(); chk("R6 lowest first", pend, 16'h0010);
    step(); chk("R6 one at a time", pend, 16'h0010);
    pulse_ret(); chk("R6 released", pend, 16'h0);
    step(); chk("R6 next", pend, 16'h0080);
    pulse_ret(); step(); chk("R6 last", pend, 16'h1000);
    pulse_ret(); evt = 16'h0; steps(2);

    cur_req = "R10";
    evt = 16'h0010; steps(3); chk("R10 taken", pend, 16'h0010);
    evt = 16'h0; step(); evt = 16'h0010; steps(2);
    rd(2'd0, v); chk("R10 relatched", v, 16'h0010);
    chk("R10 not retaken", pend, 16'h0010);
    pulse_ret(); chk("R10 released", pend, 16'h0);
    step(); chk("R10 retaken", pend, 16'h0010);
    pulse_ret(); evt = 16'h0; steps(2);

    cur_req = "R11";
    wr(2'd2, 16'hFFFF); chk("R11 pend write ignored", pend, 16'h0);
    rd(2'd2, v); chk("R11 read pend", v, 16'h0);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R11 addr3 zero", v, 16'h0);
    rd(2'd1, v); chk("R11 read mask", v, 16'hFFFF);
    steps(2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule